// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Controller

This controller sits on a synchronous clock domain and drives an external asynchronous static RAM of 512K words by 16 bits. The RAM has active-low strobes for chip select, write, output enable and two byte lanes. On the user side, a request is accepted when both valid and ready are high. The request carries a read or write flag, a 19-bit word address, 16 bits of write data and a two-bit lane mask. Reads come back on a data port together with a one-cycle valid pulse.

Every access runs as a fixed sequence. First an address setup phase holds all strobes high. Next comes either a write pulse or a read access phase. Last comes a recovery phase that again holds all strobes high. Each phase length is a whole number of clocks, found by ceiling division of the RAM's nanosecond minimums by the clock period, and is never less than one clock. The data bus is shared and bidirectional, so the controller has a separate drive-enable output. It turns on its drivers only after the RAM's output enable has been high for the turnaround time. It turns them off one clock after the write strobe rises.

Top module: `sram_lane_ctrl`

## Requirements
- R1: While reset is asserted and directly after it, ready is high, rsp_valid is low, the drive enable is low, and the chip, write, output and both lane strobes are high.
- R2: Ready goes low on the clock a request is accepted and stays low until recovery ends. With the default parameters it is low for 4 cycles on a write, 5 on a read and 1 on a request with an empty mask.
- R3: The RAM address changes only on a clock edge where the chip, write and both lane strobes are high, both before and after that edge.
- R4: In a write, chip select and write strobe are low together for WR_CYC clocks (2 by default), and output enable stays high. Mask bit 0 drives the lower lane strobe low (data bits 7..0) and mask bit 1 drives the upper lane strobe low (data bits 15..8). A lane with its mask bit clear is left unchanged in memory.
- R5: In a read, chip select and output enable are low for RD_CYC clocks (3 by default), and the write strobe stays high. The lane strobes follow the mask in the same way as in R4.
- R6: Read data is captured on the last access clock and presented with rsp_valid high for exactly one cycle. A lane with its mask bit clear reads as zero.
- R7: The drive enable is high only while output enable is high and has been high on the previous clock. It rises with the write pulse, stays high for one clock after the write strobe rises, and then drops. In total it is high for WR_CYC+1 clocks.
- R8: A request with mask 2'b00 never pulls any strobe low and does not change memory. If it is a read, it still returns rsp_valid with data 16'h0000.
- R9: Between two accesses there is at least one clock with all strobes high. The setup and recovery phases together give at least 2 such clocks per access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Controller can accept a request |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 19 | Word address |
| req_wdata_i | input | 16 | Write data |
| req_mask_i | input | 2 | Lane mask, bit 0 = bits 7..0, bit 1 = bits 15..8 |
| rsp_valid_o | output | 1 | One-cycle read data strobe |
| rsp_rdata_o | output | 16 | Read data, disabled lanes zero |
| ram_addr_o | output | 19 | RAM address |
| ram_ce_no | output | 1 | RAM chip select, active low |
| ram_we_no | output | 1 | RAM write strobe, active low |
| ram_oe_no | output | 1 | RAM output enable, active low |
| ram_lb_no | output | 1 | RAM lower lane enable, active low |
| ram_ub_no | output | 1 | RAM upper lane enable, active low |
| ram_dq_o | output | 16 | Data toward the RAM |
| ram_dq_oe_o | output | 1 | Drive enable for ram_dq_o |
| ram_dq_i | input | 16 | Data from the RAM |

## Verification
Full-word writes to distinct addresses, including the lowest and highest, followed by reads confirm the address path and the basic phase counts. Single-lane writes over known words, followed by full and single-lane reads, catch a swapped or ignored mask bit and a failure to zero a disabled lane. Requests with an empty mask show that no strobe moves and that memory is untouched. Alternating reads and writes back to back exercise the bus turnaround and the strobe-high gap. A behavioural RAM in the bench rejects any address change under a low strobe and any write without the controller driving the bus.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_WRITE,
    ST_READ,
    ST_RECOVER
  } ctl_state_e;

  function automatic int unsigned ns_to_cyc(input int unsigned ns,
                                            input int unsigned period_ns);
    int unsigned c;
    c = (ns + period_ns - 1) / period_ns;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int unsigned max3(input int unsigned a,
                                       input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    return m;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             last_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (load_i)            cnt_q <= len_i - 1'b1;
    else if (cnt_q != '0)       cnt_q <= cnt_q - 1'b1;
  end

  assign last_o = (cnt_q == '0);
endmodule

// File: rtl/sram_turn_guard.sv
module sram_turn_guard #(
  parameter int unsigned TURN_CYC = 1,
  parameter int unsigned CNT_W    = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic oe_ni,
  output logic quiet_o
);
  localparam logic [CNT_W-1:0] TURN_LIM = CNT_W'(TURN_CYC);

  logic [CNT_W-1:0] hi_cnt_q;

  // counts clocks since the RAM output enable last went high, saturating
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 hi_cnt_q <= TURN_LIM;
    else if (!oe_ni)             hi_cnt_q <= '0;
    else if (hi_cnt_q < TURN_LIM) hi_cnt_q <= hi_cnt_q + 1'b1;
  end

  assign quiet_o = (hi_cnt_q >= TURN_LIM);
endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
  import sram_lane_pkg::*;
#(
  parameter int unsigned ADDR_W    = 19,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned CLK_NS    = 4,
  parameter int unsigned T_AS_NS   = 0,
  parameter int unsigned T_WP_NS   = 8,
  parameter int unsigned T_AW_NS   = 8,
  parameter int unsigned T_DW_NS   = 6,
  parameter int unsigned T_WR_NS   = 0,
  parameter int unsigned T_RC_NS   = 10,
  parameter int unsigned T_AA_NS   = 10,
  parameter int unsigned T_OE_NS   = 5,
  parameter int unsigned T_OHZ_NS  = 4,
  parameter int unsigned T_CHZ_NS  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic [1:0]        req_mask_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic [ADDR_W-1:0] ram_addr_o,
  output logic              ram_ce_no,
  output logic              ram_we_no,
  output logic              ram_oe_no,
  output logic              ram_lb_no,
  output logic              ram_ub_no,
  output logic [DATA_W-1:0] ram_dq_o,
  output logic              ram_dq_oe_o,
  input  logic [DATA_W-1:0] ram_dq_i
);
  localparam int unsigned LANE_W    = DATA_W / 2;
  localparam int unsigned SETUP_CYC = ns_to_cyc(T_AS_NS, CLK_NS);
  localparam int unsigned WR_CYC    = ns_to_cyc(max3(T_WP_NS, T_AW_NS, T_DW_NS), CLK_NS);
  localparam int unsigned RD_CYC    = ns_to_cyc(max3(T_RC_NS, T_AA_NS, T_OE_NS), CLK_NS);
  localparam int unsigned REC_CYC   = ns_to_cyc(T_WR_NS, CLK_NS);
  localparam int unsigned TURN_CYC  = ns_to_cyc(max3(T_OHZ_NS, T_CHZ_NS, 0), CLK_NS);
  localparam int unsigned MAX_CYC   = max3(max3(SETUP_CYC, WR_CYC, RD_CYC), REC_CYC, TURN_CYC);
  localparam int unsigned CNT_W     = $clog2(MAX_CYC + 1) + 1;

  ctl_state_e state_q, state_d;

  logic              write_q;
  logic [1:0]        mask_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;
  logic              rsp_valid_q;
  logic              wr_hold_q;
  logic              accept;
  logic              empty_mask;
  logic              phase_last;
  logic              bus_quiet;
  logic              phase_load;
  logic [CNT_W-1:0]  phase_len;
  logic              access_on;
  logic [DATA_W-1:0] lane_keep;

  assign accept     = (state_q == ST_IDLE) && req_valid_i;
  assign empty_mask = (req_mask_i == 2'b00);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (req_valid_i) state_d = empty_mask ? ST_RECOVER : ST_SETUP;
      ST_SETUP:   if (phase_last && (!write_q || bus_quiet))
                    state_d = write_q ? ST_WRITE : ST_READ;
      ST_WRITE:   if (phase_last) state_d = ST_RECOVER;
      ST_READ:    if (phase_last) state_d = ST_RECOVER;
      ST_RECOVER: if (phase_last) state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    unique case (state_d)
      ST_SETUP:   phase_len = CNT_W'(SETUP_CYC);
      ST_WRITE:   phase_len = CNT_W'(WR_CYC);
      ST_READ:    phase_len = CNT_W'(RD_CYC);
      ST_RECOVER: phase_len = CNT_W'(REC_CYC);
      default:    phase_len = CNT_W'(1);
    endcase
  end

  assign phase_load = (state_d != state_q);

  sram_phase_timer #(.CNT_W(CNT_W)) phase_timer_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (phase_load),
    .len_i  (phase_len),
    .last_o (phase_last)
  );

  sram_turn_guard #(.TURN_CYC(TURN_CYC), .CNT_W(CNT_W)) turn_guard_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .oe_ni   (ram_oe_no),
    .quiet_o (bus_quiet)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      write_q <= 1'b0;
      mask_q  <= 2'b00;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      write_q <= req_write_i;
      mask_q  <= req_mask_i;
      addr_q  <= req_addr_i;
      wdata_q <= req_wdata_i;
    end
  end

  // zero out lanes that were not requested
  generate
    for (genvar g = 0; g < 2; g++) begin : g_lane
      assign lane_keep[g*LANE_W +: LANE_W] = {LANE_W{mask_q[g]}};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_q <= 1'b0;
      rdata_q     <= '0;
    end else if (state_q == ST_READ && phase_last) begin
      rsp_valid_q <= 1'b1;
      rdata_q     <= ram_dq_i & lane_keep;
    end else if (accept && !req_write_i && empty_mask) begin
      rsp_valid_q <= 1'b1;
      rdata_q     <= '0;
    end else begin
      rsp_valid_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wr_hold_q <= 1'b0;
    else         wr_hold_q <= (state_q == ST_WRITE);
  end

  assign access_on   = (state_q == ST_WRITE) || (state_q == ST_READ);
  assign req_ready_o = (state_q == ST_IDLE);
  assign rsp_valid_o = rsp_valid_q;
  assign rsp_rdata_o = rdata_q;
  assign ram_addr_o  = addr_q;
  assign ram_ce_no   = !access_on;
  assign ram_we_no   = !(state_q == ST_WRITE);
  assign ram_oe_no   = !(state_q == ST_READ);
  assign ram_lb_no   = !(access_on && mask_q[0]);
  assign ram_ub_no   = !(access_on && mask_q[1]);
  assign ram_dq_o    = wdata_q;
  assign ram_dq_oe_o = (state_q == ST_WRITE) || wr_hold_q;
endmodule

// File: rtl/sram_lane_ctrl_chk.sv
module sram_lane_ctrl_chk #(
  parameter int unsigned ADDR_W = 19,
  parameter int unsigned WR_CYC = 2,
  parameter int unsigned RD_CYC = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic              rsp_valid_o,
  input logic [ADDR_W-1:0] ram_addr_o,
  input logic              ram_ce_no,
  input logic              ram_we_no,
  input logic              ram_oe_no,
  input logic              ram_lb_no,
  input logic              ram_ub_no,
  input logic              ram_dq_oe_o
);
  logic [7:0] we_lo_cnt;
  logic [7:0] oe_lo_cnt;
  logic       all_hi;

  assign all_hi = ram_ce_no && ram_we_no && ram_lb_no && ram_ub_no;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_lo_cnt <= '0;
      oe_lo_cnt <= '0;
    end else begin
      we_lo_cnt <= ram_we_no ? 8'd0 : ((we_lo_cnt == 8'hff) ? we_lo_cnt : we_lo_cnt + 8'd1);
      oe_lo_cnt <= ram_oe_no ? 8'd0 : ((oe_lo_cnt == 8'hff) ? oe_lo_cnt : oe_lo_cnt + 8'd1);
    end
  end

  p_idle_strobes_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (all_hi && ram_oe_no && !ram_dq_oe_o));

  p_busy_after_accept_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o);

  p_addr_stable_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ram_addr_o) |-> (all_hi && $past(all_hi)));

  p_write_pulse_len_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ram_we_no) |-> (we_lo_cnt >= 8'(WR_CYC)));

  p_no_we_oe_overlap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!ram_we_no && !ram_oe_no));

  p_read_len_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ram_oe_no) |-> (oe_lo_cnt >= 8'(RD_CYC)));

  p_rsp_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);

  p_drive_turn_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_dq_oe_o |-> (ram_oe_no && $past(ram_oe_no)));

  p_release_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ram_we_no) |-> (ram_dq_oe_o ##1 !ram_dq_oe_o));

  p_lane_needed_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ram_ce_no |-> (!ram_lb_no || !ram_ub_no));

  p_gap_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ram_ce_no) |=> ram_ce_no);
endmodule

bind sram_lane_ctrl sram_lane_ctrl_chk #(
  .ADDR_W(ADDR_W),
  .WR_CYC(WR_CYC),
  .RD_CYC(RD_CYC)
) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .rsp_valid_o (rsp_valid_o),
  .ram_addr_o  (ram_addr_o),
  .ram_ce_no   (ram_ce_no),
  .ram_we_no   (ram_we_no),
  .ram_oe_no   (ram_oe_no),
  .ram_lb_no   (ram_lb_no),
  .ram_ub_no   (ram_ub_no),
  .ram_dq_oe_o (ram_dq_oe_o)
);

// File: tb/sram_lane_ctrl_tb_top.sv
module sram_lane_ctrl_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic        req_write_i = 1'b0;
  logic [18:0] req_addr_i = '0;
  logic [15:0] req_wdata_i = '0;
  logic [1:0]  req_mask_i = 2'b00;
  logic        rsp_valid_o;
  logic [15:0] rsp_rdata_o;
  logic [18:0] ram_addr_o;
  logic        ram_ce_no, ram_we_no, ram_oe_no, ram_lb_no, ram_ub_no;
  logic [15:0] ram_dq_o;
  logic        ram_dq_oe_o;
  logic [15:0] ram_dq_i;

  int errors = 0;
  int checks = 0;
  int mon_errs = 0;
  int cyc = 0;

  logic [15:0] ram_mem [int];
  logic [15:0] ref_mem [int];

  always #2 clk_i = ~clk_i;

  sram_lane_ctrl dut_i (.*);

  function automatic logic [15:0] ram_rd(input logic [18:0] a);
    return ram_mem.exists(int'(a)) ? ram_mem[int'(a)] : 16'h0000;
  endfunction

  function automatic logic [15:0] ref_rd(input logic [18:0] a);
    return ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : 16'h0000;
  endfunction

  // behavioural RAM: drives garbage on disabled lanes and when not reading
  always_comb begin
    if (!ram_ce_no && !ram_oe_no && ram_we_no) begin
      ram_dq_i[7:0]  = ram_lb_no ? 8'h5A : ram_rd(ram_addr_o)[7:0];
      ram_dq_i[15:8] = ram_ub_no ? 8'hA5 : ram_rd(ram_addr_o)[15:8];
    end else begin
      ram_dq_i = 16'hC3C3;
    end
  end

  logic [18:0] prev_addr;
  logic        prev_hi = 1'b1;
  logic        wr_pend = 1'b0;
  logic [15:0] wr_data;
  logic [1:0]  wr_lanes;
  logic [18:0] wr_addr;

  // RAM rule monitor, sampled at the falling edge
  always @(negedge clk_i) begin
    logic cur_hi;
    logic wr_act;
    logic [15:0] w;
    cur_hi = ram_ce_no && ram_we_no && ram_lb_no && ram_ub_no;
    wr_act = !ram_ce_no && !ram_we_no && (!ram_lb_no || !ram_ub_no);
    if (rst_ni) begin
      if (ram_addr_o !== prev_addr && !(cur_hi && prev_hi)) begin
        mon_errs++;
        $display("FAIL R3: address moved under low strobe, actual %h expected %h", ram_addr_o, prev_addr);
      end
      if (wr_act) begin
        if (!ram_dq_oe_o || !ram_oe_no) begin
          mon_errs++;
          $display("FAIL R7: write without bus drive, actual dq_oe=%0b oe_n=%0b expected 1 1", ram_dq_oe_o, ram_oe_no);
        end
        wr_pend  = 1'b1;
        wr_data  = ram_dq_o;
        wr_lanes = {!ram_ub_no, !ram_lb_no};
        wr_addr  = ram_addr_o;
      end else if (wr_pend) begin
        w = ram_rd(wr_addr);
        if (wr_lanes[0]) w[7:0]  = wr_data[7:0];
        if (wr_lanes[1]) w[15:8] = wr_data[15:8];
        ram_mem[int'(wr_addr)] = w;
        wr_pend = 1'b0;
      end
    end
    prev_addr = ram_addr_o;
    prev_hi   = cur_hi;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    chk(mon_errs == 0, "R3", "RAM rule monitor violations", mon_errs, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // one access; counts what the RAM pins do until ready returns
  task automatic run_access(input bit wr, input logic [18:0] a, input logic [15:0] d,
                            input logic [1:0] m,
                            output int busy, output int we_lo, output int oe_lo,
                            output int drv, output int hi, output int rsp,
                            output logic [15:0] rd, output int lane_bad);
    busy = 0; we_lo = 0; oe_lo = 0; drv = 0; hi = 0; rsp = 0; rd = '0; lane_bad = 0;
    @(negedge clk_i);
    req_valid_i = 1'b1; req_write_i = wr; req_addr_i = a; req_wdata_i = d; req_mask_i = m;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    for (int i = 0; i < 64 && !req_ready_o; i++) begin
      busy++;
      if (!ram_we_no) we_lo++;
      if (!ram_oe_no) oe_lo++;
      if (ram_dq_oe_o) drv++;
      if (ram_ce_no && ram_we_no && ram_oe_no && ram_lb_no && ram_ub_no) hi++;
      if (rsp_valid_o) begin rsp++; rd = rsp_rdata_o; end
      if (!ram_ce_no && (ram_lb_no != !m[0] || ram_ub_no != !m[1])) lane_bad++;
      if (m == 2'b00 && !(ram_ce_no && ram_we_no && ram_oe_no && ram_lb_no && ram_ub_no)) lane_bad++;
      @(negedge clk_i);
    end
    if (rsp_valid_o) rsp++;
  endtask

  task automatic do_write(input logic [18:0] a, input logic [15:0] d, input logic [1:0] m);
    int busy, we_lo, oe_lo, drv, hi, rsp, lane_bad;
    logic [15:0] rd, w;
    run_access(1'b1, a, d, m, busy, we_lo, oe_lo, drv, hi, rsp, rd, lane_bad);
    w = ref_rd(a);
    if (m[0]) w[7:0]  = d[7:0];
    if (m[1]) w[15:8] = d[15:8];
    ref_mem[int'(a)] = w;
    if (m == 2'b00) begin
      chk(busy == 1, "R8", "empty write busy cycles", busy, 1);
      chk(lane_bad == 0 && we_lo == 0, "R8", "strobe moved on empty write", lane_bad + we_lo, 0);
    end else begin
      chk(busy == 4, "R2", "write busy cycles", busy, 4);
      chk(we_lo == 2 && oe_lo == 0, "R4", "write strobe cycles (we_lo*16+oe_lo)", we_lo*16 + oe_lo, 32);
      chk(lane_bad == 0, "R4", "lane strobes vs mask", lane_bad, 0);
      chk(drv == 3, "R7", "bus drive cycles", drv, 3);
      chk(hi >= 2, "R9", "all-high cycles in access", hi, 2);
    end
    chk(rsp == 0, "R6", "response on write", rsp, 0);
  endtask

  task automatic do_read(input logic [18:0] a, input logic [1:0] m);
    int busy, we_lo, oe_lo, drv, hi, rsp, lane_bad;
    logic [15:0] rd, exp;
    run_access(1'b0, a, 16'h0, m, busy, we_lo, oe_lo, drv, hi, rsp, rd, lane_bad);
    exp = ref_rd(a) & {{8{m[1]}}, {8{m[0]}}};
    if (m == 2'b00) begin
      chk(busy == 1, "R8", "empty read busy cycles", busy, 1);
      chk(lane_bad == 0 && oe_lo == 0, "R8", "strobe moved on empty read", lane_bad + oe_lo, 0);
      chk(rsp == 1 && rd == 16'h0, "R8", "empty read response", {rsp[15:0], rd}, 32'h10000);
    end else begin
      chk(busy == 5, "R2", "read busy cycles", busy, 5);
      chk(oe_lo == 3 && we_lo == 0, "R5", "read strobe cycles (oe_lo*16+we_lo)", oe_lo*16 + we_lo, 48);
      chk(lane_bad == 0, "R5", "lane strobes vs mask", lane_bad, 0);
      chk(drv == 0, "R7", "bus driven during read", drv, 0);
      chk(rsp == 1, "R6", "response pulses", rsp, 1);
      chk(rd == exp, "R6", "read data", rd, exp);
    end
  endtask

  task automatic test_reset();
    chk(req_ready_o && !rsp_valid_o && !ram_dq_oe_o, "R1", "ready/rsp/drive in reset",
        {req_ready_o, rsp_valid_o, ram_dq_oe_o}, 3'b100);
    chk({ram_ce_no, ram_we_no, ram_oe_no, ram_lb_no, ram_ub_no} == 5'h1f, "R1", "strobes in reset",
        {ram_ce_no, ram_we_no, ram_oe_no, ram_lb_no, ram_ub_no}, 5'h1f);
    @(negedge clk_i); rst_ni = 1'b1;
    @(negedge clk_i);
    chk(req_ready_o && {ram_ce_no, ram_we_no, ram_oe_no, ram_lb_no, ram_ub_no} == 5'h1f,
        "R1", "idle after reset", {req_ready_o, ram_ce_no, ram_we_no, ram_oe_no, ram_lb_no, ram_ub_no}, 6'h3f);
  endtask

  task automatic test_full_words();
    do_write(19'h00000, 16'h1234, 2'b11);
    do_write(19'h7FFFF, 16'hBEEF, 2'b11);
    do_write(19'h2A5C3, 16'h0F0F, 2'b11);
    do_read(19'h00000, 2'b11);
    do_read(19'h7FFFF, 2'b11);
    do_read(19'h2A5C3, 2'b11);
  endtask

  task automatic test_byte_lanes();
    do_write(19'h00100, 16'hAAAA, 2'b11);
    do_write(19'h00100, 16'h1177, 2'b01);   // R4 lower lane only
    do_read(19'h00100, 2'b11);
    do_write(19'h00100, 16'h3355, 2'b10);   // R4 upper lane only
    do_read(19'h00100, 2'b11);
    do_read(19'h00100, 2'b01);              // R6 upper lane zero
    do_read(19'h00100, 2'b10);              // R6 lower lane zero
  endtask

  task automatic test_empty_mask();
    do_write(19'h00100, 16'hFFFF, 2'b00);   // R8
    do_read(19'h00100, 2'b00);
    do_read(19'h00100, 2'b11);
  endtask

  task automatic test_turnaround();
    // R7 R9 read followed at once by write, repeated
    for (int i = 0; i < 4; i++) begin
      do_read(19'(19'h40 + i), 2'b11);
      do_write(19'(19'h40 + i), 16'(16'h9000 + i*16'h0111), 2'b11);
    end
    for (int i = 0; i < 4; i++) do_read(19'(19'h40 + i), 2'b11);
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d cycles expected fewer than 100000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    test_reset();
    test_full_words();
    test_byte_lanes();
    test_empty_mask();
    test_turnaround();
    repeat (4) @(negedge clk_i);
    finish_run();
  end
endmodule